// File: doc/BRIEF.md
# Beeper and Display Clock Divider

This block turns a 1.024 MHz reference, presented as a one-cycle enable on the system clock, into two timing outputs and a gated speaker tone. A free-running 4-bit prescaler advances on every reference enable. Its lowest bit is the 512 kHz display-controller clock. When the prescaler wraps, it emits a one-cycle tick at 64 kHz.

The 64 kHz tick drives two counters. A 4-bit tone counter produces a 4 kHz square wave on its top bit. A duration counter decides how long the tone is let through. A valid key entry raises `req_short`, which asks for a 50 ms beep. A rejected entry raises `req_long`, which asks for a 400 ms beep. The speaker pin is active low, because the stage that follows it inverts. While no beep is playing, the pin rests high so that no steady current flows through the speaker.

Top module: `bp_beeper_clkdiv`

## Requirements
- R1: While reset is asserted, and right after it, `busy` is 0, `spk_n` is 1, `disp_clk` is 0 and `tick_64k` is 0.
- R2: `disp_clk` changes level on the clock edge that samples `ref_en` high, and on no other edge. It therefore runs at half the reference rate.
- R3: `tick_64k` is high for exactly one cycle on every 16th `ref_en` pulse counted from reset, and only in a cycle where `ref_en` is high.
- R4: A `req_short` pulse accepted while idle keeps `busy` high for exactly SHORT_TICKS (default 3200) `tick_64k` pulses.
- R5: A `req_long` pulse keeps `busy` high for exactly LONG_TICKS (default 25600) `tick_64k` pulses.
- R6: During a beep, a tone counter is cleared at the start and advanced by each tick. `spk_n` is low while bit 3 of that counter is 1. This makes `spk_n` low for ticks 8 to 15 of every 16 (4 kHz), counting from the start of the beep.
- R7: Whenever `busy` is 0, `spk_n` is 1.
- R8: A request that is accepted while a beep is playing restarts it. The duration is reloaded with the new length, and the tone counter is cleared.
- R9: If `req_long` and `req_short` arrive in the same cycle, the beep is long. A `req_short` that arrives while a long beep plays is ignored, and that beep's length and tone are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | One-cycle enable at the 1.024 MHz reference rate |
| req_short | input | 1 | Pulse requesting a short beep (valid entry) |
| req_long | input | 1 | Pulse requesting a long beep (invalid entry) |
| disp_clk | output | 1 | 512 kHz display-controller clock |
| tick_64k | output | 1 | One-cycle tick at 64 kHz |
| spk_n | output | 1 | Active-low tone drive for the speaker |
| busy | output | 1 | High while a beep is playing |

## Verification
The hardest situations to reach from the ports are requests that land in the middle of a beep. The stimulus has to place them after a known number of ticks. The driver does this by counting `tick_64k` pulses before it raises the second request, so the expected episode length is the ticks already consumed plus the new duration. The bench shortens the durations through parameters, so long beeps span more than one tone period. Irregular gaps between reference enables test that the divider follows `ref_en` and not the clock.

// File: rtl/bp_beeper_pkg.sv
package bp_beeper_pkg;

  typedef enum logic [1:0] {
    BEEP_NONE  = 2'd0,
    BEEP_SHORT = 2'd1,
    BEEP_LONG  = 2'd2
  } beep_kind_e;

  // Long wins over short; short cannot disturb a long beep in progress.
  function automatic beep_kind_e pick_request(input logic rq_short,
                                              input logic rq_long,
                                              input logic long_busy);
    if (rq_long)
      return BEEP_LONG;
    if (rq_short && !long_busy)
      return BEEP_SHORT;
    return BEEP_NONE;
  endfunction

  function automatic int unsigned beep_ticks(input beep_kind_e kind,
                                             input int unsigned short_len,
                                             input int unsigned long_len);
    case (kind)
      BEEP_LONG:  return long_len;
      BEEP_SHORT: return short_len;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/bp_prescaler.sv
module bp_prescaler #(
  parameter int PRE_W    = 4,
  parameter int DISP_BIT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  output logic disp_clk,
  output logic tick
);

  logic [PRE_W-1:0] pre_cnt;
  logic             pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (ref_en)
      pre_cnt <= pre_cnt + 1'b1;
  end

  assign pre_wrap = &pre_cnt;
  assign tick     = ref_en & pre_wrap;
  assign disp_clk = pre_cnt[DISP_BIT];

endmodule

// File: rtl/bp_duration_ctl.sv
module bp_duration_ctl
  import bp_beeper_pkg::*;
#(
  parameter int SHORT_TICKS = 3200,
  parameter int LONG_TICKS  = 25600,
  parameter int DUR_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_short,
  input  logic             req_long,
  output logic             busy,
  output logic             start,
  output logic             long_mode,
  output logic [DUR_W-1:0] dur_left
);

  beep_kind_e       kind;
  logic [DUR_W-1:0] load_val;

  assign kind     = pick_request(req_short, req_long, busy & long_mode);
  assign start    = (kind != BEEP_NONE);
  assign load_val = DUR_W'(beep_ticks(kind, SHORT_TICKS, LONG_TICKS));
  assign busy     = (dur_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_left  <= '0;
      long_mode <= 1'b0;
    end else if (start) begin
      dur_left  <= load_val;
      long_mode <= (kind == BEEP_LONG);
    end else if (tick && busy) begin
      dur_left  <= dur_left - 1'b1;
    end
  end

endmodule

// File: rtl/bp_tone_gen.sv
module bp_tone_gen #(
  parameter int TONE_W   = 4,
  parameter int TONE_BIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic busy,
  output logic tone_raw,
  output logic spk_n
);

  logic [TONE_W-1:0] tone_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tone_cnt <= '0;
    else if (start || !busy)
      tone_cnt <= '0;
    else if (tick)
      tone_cnt <= tone_cnt + 1'b1;
  end

  assign tone_raw = tone_cnt[TONE_BIT] & busy;
  assign spk_n    = ~tone_raw;

endmodule

// File: rtl/bp_beeper_clkdiv.sv
module bp_beeper_clkdiv #(
  parameter int SHORT_TICKS = 3200,
  parameter int LONG_TICKS  = 25600,
  parameter int PRE_W       = 4,
  parameter int TONE_W      = 4,
  parameter int TONE_BIT    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic req_short,
  input  logic req_long,
  output logic disp_clk,
  output logic tick_64k,
  output logic spk_n,
  output logic busy
);

  localparam int DUR_W = $clog2(LONG_TICKS + 1);

  logic             beep_start;
  logic             long_mode;
  logic             tone_raw;
  logic [DUR_W-1:0] dur_left;

  bp_prescaler #(.PRE_W(PRE_W), .DISP_BIT(0)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .disp_clk (disp_clk),
    .tick     (tick_64k)
  );

  bp_duration_ctl #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .DUR_W       (DUR_W)
  ) u_dur (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_64k),
    .req_short (req_short),
    .req_long  (req_long),
    .busy      (busy),
    .start     (beep_start),
    .long_mode (long_mode),
    .dur_left  (dur_left)
  );

  bp_tone_gen #(.TONE_W(TONE_W), .TONE_BIT(TONE_BIT)) u_tone (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_64k),
    .start    (beep_start),
    .busy     (busy),
    .tone_raw (tone_raw),
    .spk_n    (spk_n)
  );

endmodule

// File: rtl/bp_beeper_chk.sv
module bp_beeper_chk #(
  parameter int SHORT_TICKS = 3200,
  parameter int LONG_TICKS  = 25600,
  parameter int DUR_W       = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_en,
  input logic             req_short,
  input logic             req_long,
  input logic             disp_clk,
  input logic             tick_64k,
  input logic             spk_n,
  input logic             busy,
  input logic             long_mode,
  input logic [DUR_W-1:0] dur_left
);

  localparam logic [DUR_W-1:0] SHORT_V = DUR_W'(SHORT_TICKS);
  localparam logic [DUR_W-1:0] LONG_V  = DUR_W'(LONG_TICKS);

  // R2
  disp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |=> (disp_clk != $past(disp_clk)));

  // R2
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> $stable(disp_clk));

  // R3
  tick_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_64k |-> ref_en);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spk_n);

  // R5
  long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_long |=> (busy && long_mode && dur_left == LONG_V));

  // R4
  short_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_short && !req_long && !(busy && long_mode)) |=> (dur_left == SHORT_V));

  // R9
  short_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && long_mode && req_short && !req_long && !tick_64k)
      |=> (dur_left == $past(dur_left) && long_mode));

  // R8
  dur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dur_left <= LONG_V);

endmodule

bind bp_beeper_clkdiv bp_beeper_chk #(
  .SHORT_TICKS (SHORT_TICKS),
  .LONG_TICKS  (LONG_TICKS),
  .DUR_W       (DUR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_en    (ref_en),
  .req_short (req_short),
  .req_long  (req_long),
  .disp_clk  (disp_clk),
  .tick_64k  (tick_64k),
  .spk_n     (spk_n),
  .busy      (busy),
  .long_mode (long_mode),
  .dur_left  (dur_left)
);

// File: tb/test_bp_beeper_clkdiv.sv
module test_bp_beeper_clkdiv;

  localparam int SHORT_T = 10;
  localparam int LONG_T  = 40;

  typedef struct {
    int    ticks;
    int    falls;
    string tag;
  } episode_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic req_short = 1'b0;
  logic req_long = 1'b0;
  logic disp_clk, tick_64k, spk_n, busy;

  int checks = 0;
  int errors = 0;
  episode_t sb_q[$];

  bp_beeper_clkdiv #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) i_bp_beeper_clkdiv (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .req_short(req_short),
    .req_long(req_long), .disp_clk(disp_clk), .tick_64k(tick_64k),
    .spk_n(spk_n), .busy(busy)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Falling edges of the active-low pin within ticks first..last of one tone phase run.
  function automatic int low_starts(input int first, input int last);
    int n = 0;
    for (int k = first; k <= last; k++)
      if ((k % 16) == 8) n++;
    return n;
  endfunction

  task automatic pulse_req(input bit s, input bit l);
    @(posedge clk); #1;
    req_short = s; req_long = l;
    @(posedge clk); #1;
    req_short = 1'b0; req_long = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (tick_64k) seen++;
    end
  endtask

  task automatic wait_drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // Reference enable with irregular gaps
  initial begin
    int gap = 2;
    wait (rst_n);
    forever begin
      repeat (gap) @(posedge clk);
      #1 ref_en = 1'b1;
      @(posedge clk); #1 ref_en = 1'b0;
      gap = (gap == 4) ? 2 : gap + 1;
    end
  end

  // Monitor / scoreboard
  int  ep_ticks = 0, ep_falls = 0, ref_cnt = 0, tick_cnt = 0, disp_bad = 0;
  bit  prev_busy = 0, prev_spk = 1, prev_ref = 0, prev_disp = 0;
  initial begin
    wait (rst_n);
    @(negedge clk);
    prev_disp = disp_clk;
    forever begin
      @(negedge clk);
      if ((disp_clk != prev_disp) != prev_ref) disp_bad++;
      if (ref_en) ref_cnt++;
      if (tick_64k) tick_cnt++;
      if (busy && tick_64k) ep_ticks++;
      if (busy && prev_spk && !spk_n) ep_falls++;
      if (prev_busy && !busy) begin
        episode_t e;
        if (sb_q.size() == 0) begin
          check(0, "R4/R5 unexpected episode", ep_ticks, 0);
        end else begin
          e = sb_q.pop_front();
          check(ep_ticks == e.ticks, {e.tag, " duration"}, ep_ticks, e.ticks);
          check(ep_falls == e.falls, "R6 tone low phases", ep_falls, e.falls);
          check(spk_n == 1'b1, "R7 idle level", spk_n, 1);
        end
        ep_ticks = 0;
        ep_falls = 0;
      end
      prev_busy = busy; prev_spk = spk_n; prev_ref = ref_en; prev_disp = disp_clk;
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(spk_n == 1, "R1 spk_n", spk_n, 1);
    check(disp_clk == 0, "R1 disp_clk", disp_clk, 0);
    check(tick_64k == 0, "R1 tick_64k", tick_64k, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (200) @(negedge clk);

    // R4 short beep from idle
    sb_q.push_back('{SHORT_T, low_starts(1, SHORT_T-1), "R4 short"});
    pulse_req(1, 0);
    wait_drain();

    // R5 long beep, R6 spans two tone periods
    sb_q.push_back('{LONG_T, low_starts(1, LONG_T-1), "R5 long"});
    pulse_req(0, 1);
    wait_drain();

    // R9 both at once -> long
    sb_q.push_back('{LONG_T, low_starts(1, LONG_T-1), "R9 simultaneous"});
    pulse_req(1, 1);
    wait_drain();

    // R8 short restarted by short after 4 ticks
    sb_q.push_back('{4 + SHORT_T, low_starts(1, 4) + low_starts(1, SHORT_T-1), "R8 short retrigger"});
    pulse_req(1, 0);
    wait_ticks(4);
    pulse_req(1, 0);
    wait_drain();

    // R8 short upgraded to long after 3 ticks
    sb_q.push_back('{3 + LONG_T, low_starts(1, 3) + low_starts(1, LONG_T-1), "R8 upgrade"});
    pulse_req(1, 0);
    wait_ticks(3);
    pulse_req(0, 1);
    wait_drain();

    // R9 short during long ignored (after 9 ticks, tone already low)
    sb_q.push_back('{LONG_T, low_starts(1, LONG_T-1), "R9 short ignored"});
    pulse_req(0, 1);
    wait_ticks(9);
    pulse_req(1, 0);
    wait_drain();

    // R2, R3 divider behaviour over the whole run
    check(disp_bad == 0, "R2 disp_clk follows ref_en", disp_bad, 0);
    check(tick_cnt == ref_cnt / 16, "R3 tick count", tick_cnt, ref_cnt / 16);
    check(ref_cnt > 64, "R3 enough reference pulses", ref_cnt, 65);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule